// File: doc/BRIEF.md
# SPI Burst Transfer Engine

This block is the serial core of an SPI master. A one-cycle start request launches a burst of `burst_len` bytes. The first `tx_len` bytes of the burst are taken one at a time from a transmit queue. The remaining bytes go out as all-zero filler, so that a slave can keep answering. Every byte that arrives on MISO is handed to a receive queue, unless the caller has asked to drop receive data for the bytes that carry real transmit data. When the last byte ends, the engine reports completion with a single-cycle pulse.

The serial clock comes from a clock-enable `tick` that is generated outside the block. Each tick is one half-period of SCLK. All four SPI modes are supported, through clock polarity and clock phase. Bytes can be sent MSB-first or LSB-first. One of four chip-select lines is driven, and chip select is either automatic (active for the whole burst) or manual (the selected line simply takes a programmed pin level). The active level of chip select is configurable. The queue storage and the tick generator live outside this block.

Top module: `spi_burst_engine`

## Requirements
- R1: While `rst_n` is low: `busy`, `done`, `tx_pop` and `rx_push` are 0, `sclk` equals `cfg_cpol`, and every chip-select line sits at its inactive level.
- R2: `go` is accepted only while the engine is idle. `busy` rises in the cycle after an accepted `go`. A `go` that arrives while busy has no effect on the burst, on the byte count or on completion.
- R3: A burst shifts out exactly `burst_len` bytes. Each of the first `tx_len` bytes pops one entry of the transmit queue (`tx_pop`, only while `tx_valid` is 1). The remaining bytes are sent as 0x00 and pop nothing.
- R4: `sclk` idles at `cfg_cpol`. With `cfg_cpha`=0, MISO is sampled on the leading edge of each bit and MOSI changes on the trailing edge. With `cfg_cpha`=1, MOSI changes on the leading edge and MISO is sampled on the trailing edge.
- R5: With `cfg_lsb_first`=0, bit 7 goes out and comes in first. With `cfg_lsb_first`=1, bit 0 goes out first, and the first bit received lands in bit 0.
- R6: Each received byte is pushed to the receive queue (`rx_push` for one cycle, with `rx_data`). The exception is a byte whose index is below `tx_len` while `cfg_drop_rx`=1: it is not pushed.
- R7: After the last byte, one half-period later, `done` is high for exactly one cycle. `busy` falls in that same cycle.
- R8: If the transmit queue is empty when a data byte is due, the engine waits with `sclk` idle and no bits shifted, and resumes once `tx_valid` rises.
- R9: In automatic mode, the line `cs_o[cfg_cs_sel]` is active while `busy` is 1. It goes active at least one half-period before the first SCLK edge. All other lines stay inactive.
- R10: The active chip-select level is 1 when `cfg_cs_act_high`=1 and 0 otherwise. The inactive level is the complement.
- R11: With `cfg_cs_manual`=1, `cs_o[cfg_cs_sel]` equals `cfg_cs_level` whether or not a burst runs. The other lines stay inactive.
- R12: A `go` with `burst_len`=0 raises `done` in the next cycle. It activates no chip select, pops nothing and produces no SCLK edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick | input | 1 | Half-period clock enable for SCLK |
| go | input | 1 | Start request for a burst |
| cfg_cpol | input | 1 | SCLK idle level |
| cfg_cpha | input | 1 | Clock phase select |
| cfg_lsb_first | input | 1 | Bit order select |
| cfg_drop_rx | input | 1 | Drop receive data for data-carrying bytes |
| cfg_cs_sel | input | 2 | Chip-select line index |
| cfg_cs_manual | input | 1 | Manual chip-select mode |
| cfg_cs_level | input | 1 | Pin level of the selected line in manual mode |
| cfg_cs_act_high | input | 1 | Chip select is active high |
| burst_len | input | 24 | Total bytes in the burst |
| tx_len | input | 24 | Bytes taken from the transmit queue |
| tx_valid | input | 1 | Transmit queue is not empty |
| tx_data | input | 8 | Head of the transmit queue |
| tx_pop | output | 1 | Take the head of the transmit queue |
| rx_push | output | 1 | Write `rx_data` to the receive queue |
| rx_data | output | 8 | Received byte |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| cs_o | output | 4 | Chip-select lines |
| busy | output | 1 | Burst in progress |
| done | output | 1 | One-cycle completion pulse |

## Verification
In mode CPHA=1, two things land on the same tick: the final MISO sample of a byte and the push of that byte into the receive queue. The pushed byte therefore has to include the bit sampled on that very edge. A bench slave drives a different byte pattern in every mode, so a push that dropped the late bit would corrupt bit 0 or bit 7 and show up when the received bytes are compared against that pattern. A second coincidence is a start request that arrives while a burst is running. It is raised in the middle of a burst, and the check is that completion stays single and the count of shifted bits is unchanged.

// File: rtl/spi_burst_pkg.sv
package spi_burst_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_LOAD  = 2'd1,
    ST_SHIFT = 2'd2,
    ST_TRAIL = 2'd3
  } seq_state_e;

  // pin level of a chip-select line given whether it is asserted
  function automatic logic cs_pin(input logic asserted, input logic act_high);
    return asserted ? act_high : ~act_high;
  endfunction

endpackage

// File: rtl/spi_burst_shreg.sv
module spi_burst_shreg #(
  parameter int WORD_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [WORD_W-1:0] load_word,
  input  logic              lsb_first,
  input  logic              shift_en,
  input  logic              sample_en,
  input  logic              miso,
  output logic              mosi,
  output logic [WORD_W-1:0] rx_word
);

  logic [WORD_W-1:0] tx_sh;
  logic [WORD_W-1:0] rx_sh;

  function automatic logic [WORD_W-1:0] push_out(input logic [WORD_W-1:0] w, input logic lsb);
    return lsb ? {1'b0, w[WORD_W-1:1]} : {w[WORD_W-2:0], 1'b0};
  endfunction

  function automatic logic [WORD_W-1:0] push_in(input logic [WORD_W-1:0] w, input logic b,
                                                input logic lsb);
    return lsb ? {b, w[WORD_W-1:1]} : {w[WORD_W-2:0], b};
  endfunction

  assign mosi    = lsb_first ? tx_sh[0] : tx_sh[WORD_W-1];
  // the bit sampled in this cycle is already part of the word handed out
  assign rx_word = sample_en ? push_in(rx_sh, miso, lsb_first) : rx_sh;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_sh <= '0;
      rx_sh <= '0;
    end else begin
      if (load)          tx_sh <= load_word;
      else if (shift_en) tx_sh <= push_out(tx_sh, lsb_first);
      if (sample_en)     rx_sh <= rx_word;
    end
  end

endmodule

// File: rtl/spi_burst_csgen.sv
module spi_burst_csgen #(
  parameter int NUM_CS = 4,
  parameter int SEL_W  = 2
) (
  input  logic [SEL_W-1:0]  sel,
  input  logic              manual,
  input  logic              level,
  input  logic              act_high,
  input  logic              busy,
  output logic [NUM_CS-1:0] cs_o
);
  import spi_burst_pkg::*;

  for (genvar i = 0; i < NUM_CS; i++) begin : g_line
    assign cs_o[i] = (sel == SEL_W'(i)) ? (manual ? level : cs_pin(busy, act_high))
                                        : cs_pin(1'b0, act_high);
  end

endmodule

// File: rtl/spi_burst_engine.sv
module spi_burst_engine #(
  parameter int WORD_W = 8,
  parameter int CNT_W  = 24,
  parameter int NUM_CS = 4
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       tick,
  input  logic                       go,
  input  logic                       cfg_cpol,
  input  logic                       cfg_cpha,
  input  logic                       cfg_lsb_first,
  input  logic                       cfg_drop_rx,
  input  logic [$clog2(NUM_CS)-1:0]  cfg_cs_sel,
  input  logic                       cfg_cs_manual,
  input  logic                       cfg_cs_level,
  input  logic                       cfg_cs_act_high,
  input  logic [CNT_W-1:0]           burst_len,
  input  logic [CNT_W-1:0]           tx_len,
  input  logic                       tx_valid,
  input  logic [WORD_W-1:0]          tx_data,
  output logic                       tx_pop,
  output logic                       rx_push,
  output logic [WORD_W-1:0]          rx_data,
  output logic                       sclk,
  output logic                       mosi,
  input  logic                       miso,
  output logic [NUM_CS-1:0]          cs_o,
  output logic                       busy,
  output logic                       done
);
  import spi_burst_pkg::*;

  localparam int SEL_W = $clog2(NUM_CS);
  localparam int BIT_W = $clog2(WORD_W);
  localparam logic [BIT_W-1:0] LAST_BIT = BIT_W'(WORD_W - 1);

  seq_state_e       state;
  logic             phase;      // 0: next tick is a leading edge
  logic [BIT_W-1:0] bit_cnt;
  logic [CNT_W-1:0] byte_idx;
  logic             done_r;

  // named internal events
  logic             in_shift, lead_tick, trail_tick;
  logic             sample_en, shift_en, byte_end;
  logic             in_tx_phase, last_byte, load_ok, start_ok;
  logic [CNT_W-1:0] next_idx;
  logic [WORD_W-1:0] load_word, rx_word;

  assign in_shift    = (state == ST_SHIFT);
  assign lead_tick   = in_shift && tick && !phase;
  assign trail_tick  = in_shift && tick && phase;
  assign sample_en   = cfg_cpha ? trail_tick : lead_tick;
  assign shift_en    = cfg_cpha ? (lead_tick && (bit_cnt != '0))
                                : (trail_tick && (bit_cnt != LAST_BIT));
  assign byte_end    = trail_tick && (bit_cnt == LAST_BIT);
  assign in_tx_phase = (byte_idx < tx_len);
  assign next_idx    = byte_idx + 1'b1;
  assign last_byte   = (next_idx == burst_len);
  assign load_ok     = (state == ST_LOAD) && tick && (!in_tx_phase || tx_valid);
  assign start_ok    = go && (state == ST_IDLE);
  assign load_word   = in_tx_phase ? tx_data : '0;

  assign tx_pop  = load_ok && in_tx_phase;
  assign rx_push = byte_end && !(cfg_drop_rx && in_tx_phase);
  assign rx_data = rx_word;
  assign sclk    = cfg_cpol ^ (in_shift && phase);
  assign busy    = (state != ST_IDLE);
  assign done    = done_r;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      phase    <= 1'b0;
      bit_cnt  <= '0;
      byte_idx <= '0;
      done_r   <= 1'b0;
    end else begin
      done_r <= 1'b0;
      unique case (state)
        ST_IDLE: begin
          if (start_ok) begin
            byte_idx <= '0;
            if (burst_len == '0) done_r <= 1'b1;
            else                 state  <= ST_LOAD;
          end
        end
        ST_LOAD: begin
          if (load_ok) begin
            state   <= ST_SHIFT;
            phase   <= 1'b0;
            bit_cnt <= '0;
          end
        end
        ST_SHIFT: begin
          if (lead_tick) phase <= 1'b1;
          if (trail_tick) begin
            phase <= 1'b0;
            if (byte_end) begin
              byte_idx <= next_idx;
              state    <= last_byte ? ST_TRAIL : ST_LOAD;
            end else begin
              bit_cnt <= bit_cnt + 1'b1;
            end
          end
        end
        ST_TRAIL: begin
          if (tick) begin
            state  <= ST_IDLE;
            done_r <= 1'b1;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  spi_burst_shreg #(.WORD_W(WORD_W)) shreg_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (load_ok),
    .load_word (load_word),
    .lsb_first (cfg_lsb_first),
    .shift_en  (shift_en),
    .sample_en (sample_en),
    .miso      (miso),
    .mosi      (mosi),
    .rx_word   (rx_word)
  );

  spi_burst_csgen #(.NUM_CS(NUM_CS), .SEL_W(SEL_W)) csgen_i (
    .sel      (cfg_cs_sel),
    .manual   (cfg_cs_manual),
    .level    (cfg_cs_level),
    .act_high (cfg_cs_act_high),
    .busy     (busy),
    .cs_o     (cs_o)
  );

endmodule

// File: rtl/spi_burst_engine_chk.sv
module spi_burst_engine_chk #(
  parameter int CNT_W  = 24,
  parameter int NUM_CS = 4
) (
  input logic                      clk,
  input logic                      rst_n,
  input logic                      go,
  input logic                      busy,
  input logic                      done,
  input logic                      sclk,
  input logic                      cfg_cpol,
  input logic                      tx_pop,
  input logic                      tx_valid,
  input logic                      rx_push,
  input logic                      cfg_drop_rx,
  input logic                      in_tx_phase,
  input logic [CNT_W-1:0]          burst_len,
  input logic [NUM_CS-1:0]         cs_o,
  input logic [$clog2(NUM_CS)-1:0] cfg_cs_sel,
  input logic                      cfg_cs_manual,
  input logic                      cfg_cs_act_high
);

  // R4
  idle_clock_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> sclk == cfg_cpol);

  // R3
  pop_with_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_pop |-> tx_valid);

  // R7
  done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R7
  busy_ends_with_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> done);

  // R2
  start_from_go_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(go));

  // R6
  drop_rx_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_push |-> !(cfg_drop_rx && in_tx_phase));

  // R12
  empty_burst_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (go && !busy && burst_len == '0) |=> done);

  // R9
  cs_under_edges_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !cfg_cs_manual && !$stable(sclk)) |-> cs_o[cfg_cs_sel] == cfg_cs_act_high);

endmodule

bind spi_burst_engine spi_burst_engine_chk #(.CNT_W(CNT_W), .NUM_CS(NUM_CS)) chk_i (
  .clk             (clk),
  .rst_n           (rst_n),
  .go              (go),
  .busy            (busy),
  .done            (done),
  .sclk            (sclk),
  .cfg_cpol        (cfg_cpol),
  .tx_pop          (tx_pop),
  .tx_valid        (tx_valid),
  .rx_push         (rx_push),
  .cfg_drop_rx     (cfg_drop_rx),
  .in_tx_phase     (in_tx_phase),
  .burst_len       (burst_len),
  .cs_o            (cs_o),
  .cfg_cs_sel      (cfg_cs_sel),
  .cfg_cs_manual   (cfg_cs_manual),
  .cfg_cs_act_high (cfg_cs_act_high)
);

// File: tb/spi_burst_engine_tb_top.sv
`timescale 1ns/1ps
module spi_burst_engine_tb_top;

  typedef struct packed {
    logic       cpol;
    logic       cpha;
    logic       lsb;
    logic       drop;
    logic [1:0] sel;
    logic       hi;
    logic [4:0] burst;
    logic [4:0] txl;
  } vec_t;

  // cpol cpha lsb drop sel hi burst txl
  localparam vec_t VECS [0:5] = '{
    '{1'b0, 1'b0, 1'b0, 1'b0, 2'd0, 1'b0, 5'd4, 5'd4},
    '{1'b1, 1'b1, 1'b0, 1'b0, 2'd1, 1'b0, 5'd5, 5'd2},
    '{1'b0, 1'b1, 1'b1, 1'b1, 2'd2, 1'b1, 5'd6, 5'd3},
    '{1'b1, 1'b0, 1'b1, 1'b1, 2'd3, 1'b0, 5'd3, 5'd3},
    '{1'b0, 1'b0, 1'b0, 1'b0, 2'd0, 1'b1, 5'd3, 5'd0},
    '{1'b1, 1'b1, 1'b1, 1'b0, 2'd2, 1'b0, 5'd9, 5'd9}
  };

  logic clk = 1'b0, rst_n = 1'b0, tick = 1'b0, go = 1'b0;
  logic cfg_cpol = 1'b0, cfg_cpha = 1'b0, cfg_lsb_first = 1'b0, cfg_drop_rx = 1'b0;
  logic [1:0] cfg_cs_sel = 2'd0;
  logic cfg_cs_manual = 1'b0, cfg_cs_level = 1'b0, cfg_cs_act_high = 1'b0;
  logic [23:0] burst_len = '0, tx_len = '0;
  logic tx_valid, tx_pop, rx_push, sclk, mosi, busy, done;
  logic [7:0] tx_data, rx_data;
  logic miso = 1'b0;
  logic [3:0] cs_o;

  int errors = 0, checks = 0, vnum = 0, tx_avail = 0;
  bit clr = 1'b1;
  int tx_rd, done_cnt, pop_cnt, rx_cnt, cap_idx, s_idx, cs_bad, cs_act, tcnt;
  logic [7:0] rx_mem [0:15];
  logic [7:0] cap_mem [0:15];
  logic prev_sclk, miso_r;

  always #2.5 clk = ~clk;

  spi_burst_engine dut_i (
    .clk(clk), .rst_n(rst_n), .tick(tick), .go(go),
    .cfg_cpol(cfg_cpol), .cfg_cpha(cfg_cpha), .cfg_lsb_first(cfg_lsb_first),
    .cfg_drop_rx(cfg_drop_rx), .cfg_cs_sel(cfg_cs_sel), .cfg_cs_manual(cfg_cs_manual),
    .cfg_cs_level(cfg_cs_level), .cfg_cs_act_high(cfg_cs_act_high),
    .burst_len(burst_len), .tx_len(tx_len), .tx_valid(tx_valid), .tx_data(tx_data),
    .tx_pop(tx_pop), .rx_push(rx_push), .rx_data(rx_data), .sclk(sclk), .mosi(mosi),
    .miso(miso), .cs_o(cs_o), .busy(busy), .done(done)
  );

  function automatic logic [7:0] tbyte(input int k, input int v);
    return 8'((8'hA5 + k * 29) ^ (v * 13));
  endfunction

  function automatic logic [7:0] sbyte(input int k, input int v);
    return 8'((8'h3C ^ (k * 53)) + v * 7);
  endfunction

  function automatic logic sbit(input int idx, input int v, input logic lsb);
    logic [7:0] b;
    b = sbyte(idx / 8, v);
    return lsb ? b[idx % 8] : b[7 - (idx % 8)];
  endfunction

  // transmit queue model
  assign tx_valid = (tx_rd < tx_avail);
  assign tx_data  = tbyte(tx_rd, vnum);

  always @(posedge clk) begin
    if (clr) begin
      done_cnt <= 0; pop_cnt <= 0; rx_cnt <= 0; tx_rd <= 0;
    end else begin
      if (done) done_cnt <= done_cnt + 1;
      if (tx_pop) begin pop_cnt <= pop_cnt + 1; tx_rd <= tx_rd + 1; end
      if (rx_push) begin rx_mem[rx_cnt[3:0]] <= rx_data; rx_cnt <= rx_cnt + 1; end
    end
  end

  // half-period tick, one in three cycles
  always @(negedge clk) begin
    if (!rst_n) tcnt <= 0;
    else tcnt <= (tcnt == 2) ? 0 : tcnt + 1;
    tick <= rst_n && (tcnt == 2);
  end

  // slave model and chip-select monitor
  always @(negedge clk) begin
    logic lead, trail;
    int pos;
    if (clr) begin
      s_idx = 0; cap_idx = 0; cs_bad = 0; cs_act = 0; miso_r = 1'b0; prev_sclk = sclk;
    end else begin
      lead  = (sclk != prev_sclk) && (sclk != cfg_cpol);
      trail = (sclk != prev_sclk) && (sclk == cfg_cpol);
      if ((cfg_cpha ? trail : lead) && cap_idx < 128) begin
        pos = cfg_lsb_first ? (cap_idx % 8) : 7 - (cap_idx % 8);
        cap_mem[cap_idx / 8][pos] = mosi;
        cap_idx++;
      end
      if (cfg_cpha && lead) begin miso_r = sbit(s_idx, vnum, cfg_lsb_first); s_idx++; end
      if (!cfg_cpha && trail) s_idx++;
      prev_sclk = sclk;
      if (!cfg_cs_manual) begin
        for (int i = 0; i < 4; i++) begin
          if (cs_o[i] !== ((busy && cfg_cs_sel == 2'(i)) ? cfg_cs_act_high : ~cfg_cs_act_high))
            cs_bad++;
        end
      end
      if (cs_o[cfg_cs_sel] == cfg_cs_act_high) cs_act++;
    end
    miso <= cfg_cpha ? miso_r : sbit(s_idx, vnum, cfg_lsb_first);
  end

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic do_clr();
    step(); clr = 1'b1; step(); clr = 1'b0;
  endtask

  task automatic pulse_go();
    step(); go = 1'b1; step(); go = 1'b0;
  endtask

  task automatic set_vec(input vec_t t);
    cfg_cpol = t.cpol; cfg_cpha = t.cpha; cfg_lsb_first = t.lsb; cfg_drop_rx = t.drop;
    cfg_cs_sel = t.sel; cfg_cs_act_high = t.hi; cfg_cs_manual = 1'b0;
    burst_len = 24'(t.burst); tx_len = 24'(t.txl);
  endtask

  task automatic wait_done();
    for (int i = 0; i < 6000; i++) begin
      @(negedge clk); #1;
      if (done_cnt > 0 && !busy) break;
    end
  endtask

  task automatic judge(input int v, input vec_t t);
    int bad, n, exp_n;
    logic [7:0] e;
    bad = 0;
    for (int k = 0; k < int'(t.burst); k++) begin
      e = (k < int'(t.txl)) ? tbyte(k, v) : 8'h00;
      if (cap_mem[k] !== e) bad++;
    end
    chk(bad == 0 && cap_idx == int'(t.burst) * 8, "R3 R5 mosi bytes", bad, 0);
    exp_n = t.drop ? int'(t.burst) - int'(t.txl) : int'(t.burst);
    chk(rx_cnt == exp_n, "R6 push count", rx_cnt, exp_n);
    bad = 0; n = 0;
    for (int k = 0; k < int'(t.burst); k++) begin
      if (!(t.drop && k < int'(t.txl))) begin
        if (rx_mem[n] !== sbyte(k, v)) bad++;
        n++;
      end
    end
    chk(bad == 0, "R4 R5 received bytes", bad, 0);
    chk(done_cnt == 1 && pop_cnt == int'(t.txl), "R7 R3 done and pops", pop_cnt, t.txl);
    chk(cs_bad == 0, "R9 R10 chip-select levels", cs_bad, 0);
    chk(sclk == t.cpol && !busy, "R4 idle clock after burst", sclk, t.cpol);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=%0d expected=0", busy);
    $display("Result: errors=%0d of %0d checks", errors, checks + 1);
    $finish;
  end

  initial begin
    vec_t t;
    // reset state
    repeat (3) @(negedge clk);
    #1;
    chk(!busy && !done && !tx_pop && !rx_push, "R1 reset outputs",
        {busy, done, tx_pop, rx_push}, 0);
    chk(sclk == 1'b0 && cs_o == 4'hF, "R1 reset sclk and chip select", {sclk, cs_o}, 5'h0F);
    step(); rst_n = 1'b1;

    // table walk
    for (int v = 0; v < 6; v++) begin
      t = VECS[v];
      step(); vnum = v; set_vec(t); tx_avail = int'(t.txl);
      do_clr();
      pulse_go();
      wait_done();
      judge(v, t);
    end

    // R8 stall on empty transmit queue
    t = '{1'b0, 1'b0, 1'b0, 1'b0, 2'd1, 1'b0, 5'd3, 5'd3};
    step(); vnum = 7; set_vec(t); tx_avail = 1;
    do_clr();
    pulse_go();
    repeat (200) @(posedge clk);
    @(negedge clk); #1;
    chk(busy && cap_idx == 8 && sclk == 1'b0 && pop_cnt == 1, "R8 stall with idle clock",
        cap_idx, 8);
    step(); tx_avail = 3;
    wait_done();
    judge(7, t);

    // R2 go while busy is ignored
    t = '{1'b1, 1'b0, 1'b0, 1'b0, 2'd3, 1'b1, 5'd4, 5'd2};
    step(); vnum = 8; set_vec(t); tx_avail = 2;
    do_clr();
    pulse_go();
    repeat (30) @(posedge clk);
    pulse_go();
    wait_done();
    repeat (100) @(posedge clk);
    @(negedge clk); #1;
    chk(done_cnt == 1 && cap_idx == 32 && !busy, "R2 go during burst ignored", done_cnt, 1);
    judge(8, t);

    // R12 empty burst
    step(); burst_len = '0; tx_len = 24'd2; tx_avail = 2; cfg_cs_act_high = 1'b0;
    do_clr();
    step(); go = 1'b1;
    step(); go = 1'b0;
    chk(done == 1'b1, "R12 done after empty burst", done, 1);
    repeat (10) @(posedge clk);
    @(negedge clk); #1;
    chk(cs_act == 0 && pop_cnt == 0 && !busy && cap_idx == 0, "R12 nothing moves",
        cs_act, 0);

    // R11 manual chip select
    step(); cfg_cs_manual = 1'b1; cfg_cs_sel = 2'd2; cfg_cs_act_high = 1'b0; cfg_cs_level = 1'b0;
    @(negedge clk); #1;
    chk(cs_o == 4'b1011, "R11 manual level low", cs_o, 4'b1011);
    step(); cfg_cs_level = 1'b1;
    @(negedge clk); #1;
    chk(cs_o == 4'b1111, "R11 manual level high", cs_o, 4'b1111);
    step(); cfg_cs_act_high = 1'b1;
    @(negedge clk); #1;
    chk(cs_o == 4'b0100, "R11 R10 manual with active-high idle lines", cs_o, 4'b0100);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule